// File: doc/BRIEF.md
# AUX Request to I2C Bridge

This block executes display-link auxiliary-channel requests that arrive already decoded as a command, an address, a byte count and up to sixteen bytes of write data. Native requests are served one byte per access from a 1 MiB register space behind a byte-wide memory port. I2C-over-AUX requests drive a byte-level I2C master through a command channel with a valid/ready handshake. The master offers four operations: start with address and direction, write a byte, read a byte, and stop.

Each request ends with a one-cycle reply carrying a 2-bit code and the bytes that were read. Requests that carry the middle-of-transaction flag leave the I2C transaction open once they finish. A later flagged request to the same target with the same command then continues that transaction with no new start. If the target or the command changes, the block sends a stop and then a fresh start.

Top module: `aux_i2c_bridge`

## Requirements
- R1: A native write (command 1000) stores byte i of `req_wdata` (bits 8i+7..8i) at address `req_addr`+i for i from 0 to `req_len`-1, one memory access per byte, and replies ACK (code 00).
- R2: A native read (command 1001) returns the byte from address `req_addr`+i in bits 8i+7..8i of `rsp_rdata` and replies ACK. Bytes beyond the length read as zero.
- R3: If a native memory access reports `mem_err`, no further memory access is made for that request and the reply is NACK (code 01).
- R4: A plain I2C request (write 0000, read 0001) first issues a stop if a transaction is open. It then issues a start carrying `req_addr[6:0]`, with `i2c_rd` high for a read.
- R5: If the start of an I2C request is not acknowledged, the block moves no data, issues a stop, and replies I2C_NACK (code 10).
- R6: A plain I2C request always ends with a stop. A failed data byte abandons the remaining bytes and gives I2C_NACK. Otherwise the reply is ACK.
- R7: A flagged request (write 0100, read 0101) issues a start only when no transaction is open. When one is open and both the full address and the command equal those of the last flagged start, it goes straight to the data bytes.
- R8: A flagged request finding an open transaction with a different address or command issues a stop and then a new start.
- R9: A flagged request whose bytes all succeed replies ACK and issues no stop, leaving the transaction open.
- R10: A failed data byte in a flagged request causes a stop and an I2C_NACK reply, and the transaction is closed afterwards.
- R11: Any command code outside the six above, and any length outside 1..16, is answered NACK with no memory access and no I2C operation.
- R12: Synchronous reset closes the I2C transaction, so the first flagged request after reset issues a start. After reset `req_ready` is high and `rsp_valid` low.
- R13: `req_ready` is high when idle and also in the reply cycle. A request presented during the reply cycle is accepted there without disturbing the reply being given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Native address or I2C target in bits 6..0 |
| req_len | input | 5 | Byte count, 1..16 |
| req_wdata | input | 128 | Write bytes, byte i at bits 8i+7..8i |
| rsp_valid | output | 1 | Reply pulse |
| rsp_code | output | 2 | 00 ACK, 01 NACK, 10 I2C_NACK |
| rsp_rdata | output | 128 | Read bytes, zero-filled |
| mem_en | output | 1 | Native access request |
| mem_we | output | 1 | Native access is a write |
| mem_addr | output | 20 | Native byte address |
| mem_wdata | output | 8 | Native write byte |
| mem_ready | input | 1 | Native access completes this cycle |
| mem_err | input | 1 | Native access failed |
| mem_rdata | input | 8 | Native read byte |
| i2c_valid | output | 1 | I2C operation offered |
| i2c_op | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| i2c_addr | output | 7 | Target address for start |
| i2c_rd | output | 1 | Direction for start, 1 read |
| i2c_wdata | output | 8 | Byte for write |
| i2c_ready | input | 1 | Operation completes this cycle |
| i2c_nack | input | 1 | Start or write not acknowledged |
| i2c_rdata | input | 8 | Byte from read |

## Verification
The reply pulse for one request can share its cycle with the acceptance of the next request, because `req_ready` stays high in the reply cycle. The bench provokes this on every transaction by presenting the next request at the same falling edge on which it samples the reply. It uses invalid commands, which reply in the very next cycle, so replies come back to back. Each reply's code and data are compared with a bench reference model, and the start, stop, data and memory-access counts are compared per request. A corrupted reply, or an open-transaction state updated out of order, therefore shows up on the following request.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;
  typedef enum logic [1:0] {RSP_ACK = 2'b00, RSP_NACK = 2'b01, RSP_I2C_NACK = 2'b10} rsp_code_e;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} i2c_op_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_NAT, ST_PRESTOP, ST_START, ST_DATA, ST_POSTSTOP, ST_REPLY
  } br_state_e;
  typedef struct packed {
    logic valid;
    logic native;
    logic mot;
    logic rd;
  } cmd_info_t;
endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
  import aux_bridge_pkg::*;
#(
  parameter int LW     = 5,
  parameter int MAXLEN = 16
) (
  input  logic [3:0]    cmd,
  input  logic [LW-1:0] len,
  output cmd_info_t     info
);
  logic code_ok, len_ok;
  // bit1 must be clear; native codes must not carry the continuation flag
  assign code_ok     = !cmd[1] && !(cmd[3] && cmd[2]);
  assign len_ok      = (len != '0) && (len <= LW'(MAXLEN));
  assign info.valid  = code_ok && len_ok;
  assign info.native = cmd[3];
  assign info.mot    = cmd[2] && !cmd[3];
  assign info.rd     = cmd[0];
endmodule

// File: rtl/aux_mot_tracker.sv
module aux_mot_tracker #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          set_open,
  input  logic          rec,
  input  logic [AW-1:0] rec_addr,
  input  logic [3:0]    rec_cmd,
  input  logic [AW-1:0] cmp_addr,
  input  logic [3:0]    cmp_cmd,
  output logic          open_o,
  output logic          match_o
);
  logic          open_q;
  logic [AW-1:0] last_addr_q;
  logic [3:0]    last_cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q      <= 1'b0;
      last_addr_q <= '0;
      last_cmd_q  <= '0;
    end else begin
      if (clr)           open_q <= 1'b0;
      else if (set_open) open_q <= 1'b1;
      if (rec) begin
        last_addr_q <= rec_addr;
        last_cmd_q  <= rec_cmd;
      end
    end
  end

  assign open_o  = open_q;
  assign match_o = (cmp_addr == last_addr_q) && (cmp_cmd == last_cmd_q);

  // R12: the cycle after reset the transaction is closed
  assert_reset_closed_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !open_q);
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_bridge_pkg::*;
#(
  parameter int AW     = 20,
  parameter int MAXLEN = 16,
  parameter int I2C_AW = 7,
  parameter int LW     = $clog2(MAXLEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [3:0]            req_cmd,
  input  logic [AW-1:0]         req_addr,
  input  logic [LW-1:0]         req_len,
  input  logic [MAXLEN*8-1:0]   req_wdata,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_code,
  output logic [MAXLEN*8-1:0]   rsp_rdata,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [7:0]            mem_wdata,
  input  logic                  mem_ready,
  input  logic                  mem_err,
  input  logic [7:0]            mem_rdata,
  output logic                  i2c_valid,
  output logic [1:0]            i2c_op,
  output logic [I2C_AW-1:0]     i2c_addr,
  output logic                  i2c_rd,
  output logic [7:0]            i2c_wdata,
  input  logic                  i2c_ready,
  input  logic                  i2c_nack,
  input  logic [7:0]            i2c_rdata
);
  localparam int IW = $clog2(MAXLEN);

  br_state_e           st_q;
  cmd_info_t           info_d, info_q;
  logic [3:0]          cmd_q;
  logic [AW-1:0]       addr_q;
  logic [LW-1:0]       len_q;
  logic [IW-1:0]       idx_q;
  logic [MAXLEN*8-1:0] wbuf_q, rbuf_q;
  rsp_code_e           code_q;
  logic                accept, last_byte, mot_open, mot_match;
  logic                trk_clr, trk_set, trk_rec;
  logic [7:0]          wbyte;

  aux_cmd_decode #(.LW(LW), .MAXLEN(MAXLEN)) u_dec (
    .cmd(req_cmd), .len(req_len), .info(info_d));

  assign trk_clr = ((st_q == ST_PRESTOP) || (st_q == ST_POSTSTOP)) && i2c_ready;
  assign trk_set = (st_q == ST_START) && i2c_ready && !i2c_nack;
  assign trk_rec = trk_set && info_q.mot;

  aux_mot_tracker #(.AW(AW)) u_trk (
    .clk(clk), .rst(rst), .clr(trk_clr), .set_open(trk_set), .rec(trk_rec),
    .rec_addr(addr_q), .rec_cmd(cmd_q), .cmp_addr(req_addr), .cmp_cmd(req_cmd),
    .open_o(mot_open), .match_o(mot_match));

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_REPLY);
  assign accept    = req_valid && req_ready;
  assign last_byte = (LW'(idx_q) == len_q - LW'(1));
  assign wbyte     = wbuf_q[{idx_q, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      info_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      code_q <= RSP_ACK;
    end else if (accept) begin
      info_q <= info_d;
      cmd_q  <= req_cmd;
      addr_q <= req_addr;
      len_q  <= req_len;
      idx_q  <= '0;
      wbuf_q <= req_wdata;
      rbuf_q <= '0;
      code_q <= RSP_ACK;
      if (!info_d.valid) begin
        code_q <= RSP_NACK;
        st_q   <= ST_REPLY;
      end else if (info_d.native)      st_q <= ST_NAT;
      else if (!info_d.mot)            st_q <= mot_open ? ST_PRESTOP : ST_START;
      else if (!mot_open)              st_q <= ST_START;
      else                             st_q <= mot_match ? ST_DATA : ST_PRESTOP;
    end else begin
      case (st_q)
        ST_NAT: if (mem_ready) begin
          if (mem_err) begin
            code_q <= RSP_NACK;
            st_q   <= ST_REPLY;
          end else begin
            if (info_q.rd) rbuf_q[{idx_q, 3'b000} +: 8] <= mem_rdata;
            if (last_byte) st_q <= ST_REPLY;
            else           idx_q <= idx_q + 1'b1;
          end
        end
        ST_PRESTOP: if (i2c_ready) st_q <= ST_START;
        ST_START: if (i2c_ready) begin
          if (i2c_nack) begin
            code_q <= RSP_I2C_NACK;
            st_q   <= ST_POSTSTOP;
          end else st_q <= ST_DATA;
        end
        ST_DATA: if (i2c_ready) begin
          if (i2c_nack) begin
            code_q <= RSP_I2C_NACK;
            st_q   <= ST_POSTSTOP;
          end else begin
            if (info_q.rd) rbuf_q[{idx_q, 3'b000} +: 8] <= i2c_rdata;
            if (last_byte) st_q <= info_q.mot ? ST_REPLY : ST_POSTSTOP;
            else           idx_q <= idx_q + 1'b1;
          end
        end
        ST_POSTSTOP: if (i2c_ready) st_q <= ST_REPLY;
        ST_REPLY: st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_en    = (st_q == ST_NAT);
  assign mem_we    = !info_q.rd;
  assign mem_addr  = addr_q + AW'(idx_q);
  assign mem_wdata = wbyte;

  always_comb begin
    i2c_valid = 1'b1;
    case (st_q)
      ST_PRESTOP, ST_POSTSTOP: i2c_op = OP_STOP;
      ST_START:                i2c_op = OP_START;
      ST_DATA:                 i2c_op = info_q.rd ? OP_READ : OP_WRITE;
      default: begin
        i2c_op    = OP_STOP;
        i2c_valid = 1'b0;
      end
    endcase
  end
  assign i2c_addr  = addr_q[I2C_AW-1:0];
  assign i2c_rd    = info_q.rd;
  assign i2c_wdata = wbyte;

  assign rsp_valid = (st_q == ST_REPLY);
  assign rsp_code  = code_q;
  assign rsp_rdata = rbuf_q;

  // R1: a stalled native access holds its address
  assert_mem_hold_R1: assert property (@(posedge clk) disable iff (rst)
    mem_en && !mem_ready |=> mem_en && $stable(mem_addr));
  // R4: a stalled I2C operation holds its kind
  assert_i2c_hold_R4: assert property (@(posedge clk) disable iff (rst)
    i2c_valid && !i2c_ready |=> i2c_valid && $stable(i2c_op));
  // R7: data bytes move only inside an open transaction
  assert_data_open_R7: assert property (@(posedge clk) disable iff (rst)
    i2c_valid && ((i2c_op == OP_WRITE) || (i2c_op == OP_READ)) |-> mot_open);
  // R10: an I2C_NACK reply leaves the transaction closed
  assert_nack_closed_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_code == RSP_I2C_NACK) |-> !mot_open);
  // R6: a plain I2C reply leaves the transaction closed
  assert_plain_closed_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && info_q.valid && !info_q.native && !info_q.mot |-> !mot_open);
  // R3: reply code is always one of the three defined values
  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_code != 2'b11);
endmodule

// File: tb/aux_i2c_bridge_tb.sv
`timescale 1ns/1ps
module aux_i2c_bridge_tb_top;
  import aux_bridge_pkg::*;
  localparam int AW = 20;
  localparam int ML = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, req_valid, req_ready, rsp_valid;
  logic [3:0] req_cmd;
  logic [AW-1:0] req_addr;
  logic [4:0] req_len;
  logic [ML*8-1:0] req_wdata, rsp_rdata;
  logic [1:0] rsp_code;
  logic mem_en, mem_we, mem_ready, mem_err;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic i2c_valid, i2c_rd, i2c_ready, i2c_nack;
  logic [1:0] i2c_op;
  logic [6:0] i2c_addr;
  logic [7:0] i2c_wdata, i2c_rdata;

  aux_i2c_bridge dut_i (.*);

  int checks = 0, errors = 0;
  // environment models
  logic [7:0] mmem [0:255];
  logic [7:0] smem [0:255];
  int m_acc = 0, n_start = 0, n_stop = 0, n_data = 0;
  logic [7:0] rd_ctr = 8'h00;
  logic [6:0] last_sa = '0;
  logic last_srd = 1'b0;

  assign mem_rdata = mmem[mem_addr[7:0]];
  assign mem_err   = (mem_addr[19:16] == 4'hF);
  assign i2c_nack  = (i2c_op == OP_START) ? !((i2c_addr == 7'h50) || (i2c_addr == 7'h51)) :
                     (i2c_op == OP_WRITE) ? (i2c_wdata == 8'hEE) : 1'b0;
  assign i2c_rdata = rd_ctr;

  always @(posedge clk) begin
    if (mem_en && mem_ready) begin
      m_acc <= m_acc + 1;
      if (mem_we && !mem_err) mmem[mem_addr[7:0]] <= mem_wdata;
    end
    if (i2c_valid && i2c_ready) begin
      case (i2c_op)
        OP_START: begin n_start <= n_start + 1; last_sa <= i2c_addr; last_srd <= i2c_rd; end
        OP_WRITE: n_data <= n_data + 1;
        OP_READ:  begin n_data <= n_data + 1; rd_ctr <= rd_ctr + 8'd1; end
        default:  n_stop <= n_stop + 1;
      endcase
    end
  end

  always @(negedge clk) begin
    mem_ready <= ($urandom % 4) != 0;
    i2c_ready <= ($urandom % 4) != 0;
  end

  // reference state
  bit b_open = 0;
  logic [19:0] b_last_addr = '0;
  logic [3:0] b_last_cmd = '0;
  logic [7:0] b_rdctr = 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ref_model(input logic [3:0] c, input logic [19:0] a, input logic [4:0] l,
                           input logic [127:0] w, output logic [1:0] code,
                           output logic [127:0] rd, output int st, output int sp,
                           output int dt, output int ac);
    bit valid, need, ok;
    logic [19:0] aa;
    valid = !c[1] && !(c[3] && c[2]) && (l >= 1) && (l <= 16);
    rd = '0; st = 0; sp = 0; dt = 0; ac = 0; code = 2'b00;
    if (!valid) code = 2'b01;
    else if (c[3]) begin
      for (int i = 0; i < int'(l); i++) begin
        aa = a + 20'(i);
        ac++;
        if (aa[19:16] == 4'hF) begin code = 2'b01; break; end
        if (c[0]) rd[i*8 +: 8] = smem[aa[7:0]];
        else smem[aa[7:0]] = w[i*8 +: 8];
      end
    end else begin
      need = 1; ok = 1;
      if (!c[2]) begin
        if (b_open) begin sp++; b_open = 0; end
      end else if (b_open) begin
        if (a == b_last_addr && c == b_last_cmd) need = 0;
        else begin sp++; b_open = 0; end
      end
      if (need) begin
        st++;
        if (!((a[6:0] == 7'h50) || (a[6:0] == 7'h51))) begin
          code = 2'b10; sp++; ok = 0;
        end else begin
          b_open = 1;
          if (c[2]) begin b_last_addr = a; b_last_cmd = c; end
        end
      end
      if (ok) begin
        for (int i = 0; i < int'(l); i++) begin
          dt++;
          if (c[0]) begin rd[i*8 +: 8] = b_rdctr; b_rdctr++; end
          else if (w[i*8 +: 8] == 8'hEE) begin code = 2'b10; break; end
        end
        if (code == 2'b10 || !c[2]) begin sp++; b_open = 0; end
      end
    end
  endtask

  task automatic run_req(input logic [3:0] c, input logic [19:0] a, input logic [4:0] l,
                         input logic [127:0] w, input string req);
    logic [1:0] e_code;
    logic [127:0] e_rd;
    int e_st, e_sp, e_dt, e_ac, s_st, s_sp, s_dt, s_ac;
    ref_model(c, a, l, w, e_code, e_rd, e_st, e_sp, e_dt, e_ac);
    while (!req_ready) @(negedge clk);
    s_st = n_start; s_sp = n_stop; s_dt = n_data; s_ac = m_acc;
    req_valid = 1; req_cmd = c; req_addr = a; req_len = l; req_wdata = w;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_code == e_code, req, "reply code", 128'(rsp_code), 128'(e_code));
    if (c[0] && e_code == 2'b00)
      chk(rsp_rdata == e_rd, req, "read data", rsp_rdata, e_rd);
    chk({16'(n_start - s_st), 16'(n_stop - s_sp), 16'(n_data - s_dt), 16'(m_acc - s_ac)} ==
        {16'(e_st), 16'(e_sp), 16'(e_dt), 16'(e_ac)}, req, "start/stop/data/mem counts",
        128'({16'(n_start - s_st), 16'(n_stop - s_sp), 16'(n_data - s_dt), 16'(m_acc - s_ac)}),
        128'({16'(e_st), 16'(e_sp), 16'(e_dt), 16'(e_ac)}));
    if (e_st > 0)
      chk({last_sa, last_srd} == {a[6:0], c[0]}, req, "start address/direction",
          128'({last_sa, last_srd}), 128'({a[6:0], c[0]}));
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    b_open = 0; b_last_addr = '0; b_last_cmd = '0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !i2c_valid && !mem_en, "R12", "idle after reset",
        128'({req_ready, rsp_valid, i2c_valid, mem_en}), 128'(4'b1000));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=hang expected=reply");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] c;
    logic [19:0] a;
    logic [4:0] l;
    logic [127:0] w;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin mmem[i] = 8'(i) ^ 8'h5A; smem[i] = 8'(i) ^ 8'h5A; end
    rst = 1; req_valid = 0; req_cmd = 0; req_addr = 0; req_len = 0; req_wdata = 0;
    do_reset();
    run_req(4'b1000, 20'h00010, 5'd4, 128'hA4A3A2A1, "R1");
    run_req(4'b1001, 20'h0000E, 5'd8, '0, "R2");
    run_req(4'b1001, 20'h00000, 5'd16, '0, "R2");
    run_req(4'b1000, 20'hEFFFE, 5'd4, 128'h44332211, "R3");
    run_req(4'b1001, 20'hF0000, 5'd1, '0, "R3");
    run_req(4'b0100, 20'h00050, 5'd2, 128'h0201, "R7");
    run_req(4'b0100, 20'h00050, 5'd3, 128'h030201, "R9");
    run_req(4'b0101, 20'h00050, 5'd2, '0, "R8");
    run_req(4'b0101, 20'h00051, 5'd1, '0, "R8");
    run_req(4'b0000, 20'h00050, 5'd2, 128'h1122, "R4");
    run_req(4'b0001, 20'h00051, 5'd3, '0, "R6");
    run_req(4'b0000, 20'h00033, 5'd2, 128'h1122, "R5");
    run_req(4'b0100, 20'h00034, 5'd1, 128'h77, "R5");
    run_req(4'b0000, 20'h00050, 5'd3, 128'h33EE11, "R6");
    run_req(4'b0100, 20'h00051, 5'd2, 128'h0101, "R9");
    run_req(4'b0100, 20'h00051, 5'd3, 128'h22EE11, "R10");
    run_req(4'b0100, 20'h00051, 5'd1, 128'h05, "R10");
    run_req(4'b0010, 20'h00050, 5'd1, '0, "R11");
    run_req(4'b1100, 20'h00010, 5'd1, '0, "R11");
    run_req(4'b1001, 20'h00010, 5'd0, '0, "R11");
    run_req(4'b0101, 20'h00050, 5'd17, '0, "R11");
    run_req(4'b1111, 20'h00050, 5'd2, '0, "R13");
    run_req(4'b1010, 20'h00050, 5'd2, '0, "R13");
    run_req(4'b0101, 20'h00050, 5'd1, '0, "R13");
    do_reset();
    run_req(4'b0101, 20'h00050, 5'd1, '0, "R12");
    for (int n = 0; n < 250; n++) begin
      case ($urandom % 8)
        0: c = 4'b1000; 1: c = 4'b1001; 2: c = 4'b0000; 3: c = 4'b0001;
        4, 5: c = 4'b0100; 6: c = 4'b0101;
        default: c = 4'($urandom);
      endcase
      if (c[3]) a = ($urandom % 3 == 0) ? 20'hEFFF0 + 20'($urandom % 32) : 20'($urandom % 256);
      else case ($urandom % 4) 0, 1: a = 20'h50; 2: a = 20'h51; default: a = 20'h33; endcase
      l = ($urandom % 10 == 0) ? 5'($urandom % 18) : 5'(1 + $urandom % 16);
      w = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 5 == 0) w[8*($urandom % 4) +: 8] = 8'hEE;
      run_req(c, a, l, w, "R13");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule